// File: doc/BRIEF.md
# Two-Set Four-Way Write-Back Byte Cache

This block is a small data cache for a processor with 8-bit byte addresses. Storage is organised as two sets of four ways, and each line holds two bytes. The processor issues one byte read or byte write at a time through a valid/ready request port. Each request gets back a single-cycle response that says whether it hit and carries a data byte.

Writes follow a write-back, write-allocate policy. A write that misses first brings the line in from memory. The byte is then merged into the line and the line is marked dirty. Memory sees whole-line transfers only: a line fill, or a write-back of a dirty victim. When a miss finds a dirty victim, the write-back always completes before the fill is requested.

Victim selection works in two steps. An invalid way in the indexed set is used first, taking the lowest-numbered one. Once all four ways of the set are valid, the victim comes from a free-running pseudo-random sequence sampled at the miss.

Top module: `bcache_top`

## Requirements
- R1: After reset every line is invalid and clean. `req_ready` is high, `resp_valid` and `mem_valid` are low, and the first access to any address misses.
- R2: Address bit 0 selects the byte within a line, bit 1 selects the set and bits 7..2 form the tag. On the memory data buses, bits 7..0 hold the byte at offset 0 and bits 15..8 hold the byte at offset 1. A read returns the most recently written value of the addressed byte, or the memory value if that byte was never written. A write returns its own data byte on `resp_rdata`.
- R3: A hit responds with `resp_hit`=1 and causes no memory transaction.
- R4: A miss causes exactly one fill, with `mem_write`=0 and `mem_addr` equal to the request address with bit 0 cleared. It then responds with `resp_hit`=0.
- R5: Write-allocate applies to writes. A write miss fills the line and then merges the byte, leaving the other byte of the line unchanged. A write hit makes no memory transaction.
- R6: A miss whose victim is dirty first writes that victim back with `mem_write`=1. This transfer carries the victim's own line address and its current two bytes, and it finishes before the fill starts. The written-back data is what later fills return.
- R7: A miss whose victim is clean makes no write-back.
- R8: Invalid ways are filled before any eviction, so four distinct tags in one set all stay resident.
- R9: Victim choice is confined to the indexed set. A miss in one set never removes a line of the other set.
- R10: Only one request is in flight at a time, and `req_ready` is high only while the block is idle. `resp_valid` pulses for exactly one cycle per request. A memory request holds its address and direction stable until `mem_ready`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Processor request present |
| req_ready | output | 1 | Block idle, request accepted when valid |
| req_write | input | 1 | 1 = byte write, 0 = byte read |
| req_addr | input | 8 | Byte address |
| req_wdata | input | 8 | Write byte |
| resp_valid | output | 1 | One-cycle response strobe |
| resp_hit | output | 1 | 1 = request hit, 0 = it needed a fill |
| resp_rdata | output | 8 | Read byte, or written byte for writes |
| mem_valid | output | 1 | Memory line transfer requested |
| mem_write | output | 1 | 1 = write-back, 0 = fill |
| mem_addr | output | 8 | Line base address (bit 0 zero) |
| mem_wdata | output | 16 | Write-back line data |
| mem_ready | input | 1 | Memory completes the transfer this cycle |
| mem_rdata | input | 16 | Fill line data, valid with mem_ready |

## Verification
The embedded properties assume three things about the memory side. `mem_ready` is raised only while `mem_valid` is high, it lasts a single cycle per transfer, and fill data is presented in that same cycle. They also assume that request fields stay steady while `req_valid` waits for `req_ready`. The bench memory follows these rules: it answers each transfer after zero to two idle cycles and drops `mem_ready` straight after the accepting edge. Its processor driver keeps the request steady until acceptance and issues nothing more until the response pulse has been seen. The random phase keeps to this protocol and varies only addresses, directions and data.

// File: rtl/bcache_pkg.sv
package bcache_pkg;
  // Geometry; sets, ways and line bytes are powers of two.
  localparam int ADDR_W     = 8;
  localparam int LINE_BYTES = 2;
  localparam int SETS       = 2;
  localparam int WAYS       = 4;
  localparam int RND_W      = 8;

  localparam int OFF_W  = $clog2(LINE_BYTES);
  localparam int IDX_W  = $clog2(SETS);
  localparam int WAY_W  = $clog2(WAYS);
  localparam int TAG_W  = ADDR_W - OFF_W - IDX_W;
  localparam int LINE_W = 8 * LINE_BYTES;
  localparam int LINES  = SETS * WAYS;
  localparam int LSEL_W = IDX_W + WAY_W;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOOKUP,
    ST_WBACK,
    ST_FILL,
    ST_RESP
  } ctrl_state_t;
endpackage

// File: rtl/bcache_lfsr.sv
module bcache_lfsr
  import bcache_pkg::*;
#(
  parameter int               W    = RND_W,
  parameter logic [RND_W-1:0] TAPS = 8'hB8
) (
  input  logic             clk,
  input  logic             rst_n,
  output logic [WAY_W-1:0] rnd_way
);
  logic [W-1:0] q, q_nxt;

  // Galois step, free running every cycle
  always_comb begin
    q_nxt = {1'b0, q[W-1:1]};
    if (q[0]) q_nxt = q_nxt ^ TAPS[W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= {{(W-1){1'b0}}, 1'b1};
    else        q <= q_nxt;
  end

  assign rnd_way = q[WAY_W-1:0];

  // A stuck-at-zero register would pin the victim to way 0
  assert_lfsr_alive_R9: assert property (@(posedge clk) disable iff (!rst_n)
    q != '0);
endmodule

// File: rtl/bcache_tags.sv
module bcache_tags
  import bcache_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] lk_idx,
  input  logic [TAG_W-1:0] lk_tag,
  input  logic [WAY_W-1:0] rnd_way,
  output logic             hit,
  output logic [WAY_W-1:0] hit_way,
  output logic [WAY_W-1:0] vic_way,
  output logic             vic_valid,
  output logic             vic_dirty,
  output logic [TAG_W-1:0] vic_tag,
  input  logic             fill_en,
  input  logic             dirty_en,
  input  logic [IDX_W-1:0] upd_idx,
  input  logic [WAY_W-1:0] upd_way,
  input  logic [TAG_W-1:0] fill_tag
);
  logic [LINES-1:0] valid_v, dirty_v;
  logic [TAG_W-1:0] tag_a [LINES];

  for (genvar g = 0; g < LINES; g++) begin : g_line
    logic             v_q, d_q, sel;
    logic [TAG_W-1:0] t_q;

    assign sel = ({upd_idx, upd_way} == LSEL_W'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        v_q <= 1'b0;
        d_q <= 1'b0;
      end else if (fill_en && sel) begin
        v_q <= 1'b1;
        d_q <= 1'b0;
      end else if (dirty_en && sel) begin
        d_q <= 1'b1;
      end
    end

    always_ff @(posedge clk) begin
      if (fill_en && sel) t_q <= fill_tag;
    end

    assign valid_v[g] = v_q;
    assign dirty_v[g] = d_q;
    assign tag_a[g]   = t_q;

    // A dirty mark is only ever placed on a resident line
    assert_dirty_resident_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (dirty_en && sel) |-> v_q);
  end

  logic [WAYS-1:0] set_valid, set_dirty, way_hit;
  assign set_valid = valid_v[lk_idx*WAYS +: WAYS];
  assign set_dirty = dirty_v[lk_idx*WAYS +: WAYS];

  always_comb begin
    for (int w = 0; w < WAYS; w++)
      way_hit[w] = set_valid[w] && (tag_a[{lk_idx, WAY_W'(w)}] == lk_tag);
  end

  always_comb begin
    hit_way = '0;
    for (int w = 0; w < WAYS; w++)
      if (way_hit[w]) hit_way = WAY_W'(w);
  end
  assign hit = |way_hit;

  // Lowest invalid way first, otherwise the random way
  always_comb begin
    vic_way = rnd_way;
    for (int w = WAYS - 1; w >= 0; w--)
      if (!set_valid[w]) vic_way = WAY_W'(w);
  end

  assign vic_valid = set_valid[vic_way];
  assign vic_dirty = set_dirty[vic_way];
  assign vic_tag   = tag_a[{lk_idx, vic_way}];

  // No tag may be resident twice within one set
  assert_single_match_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(way_hit));
endmodule

// File: rtl/bcache_data.sv
module bcache_data
  import bcache_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDX_W-1:0]  rd_idx,
  input  logic [WAY_W-1:0]  rd_way,
  output logic [LINE_W-1:0] rd_line,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [WAY_W-1:0]  wr_way,
  input  logic              fill_en,
  input  logic [LINE_W-1:0] fill_line,
  input  logic              byte_en,
  input  logic [OFF_W-1:0]  byte_off,
  input  logic [7:0]        byte_data
);
  logic [LINE_W-1:0] line_a [LINES];

  for (genvar g = 0; g < LINES; g++) begin : g_line
    logic              sel;
    logic [LINE_W-1:0] line_q;

    assign sel = ({wr_idx, wr_way} == LSEL_W'(g));

    always_ff @(posedge clk) begin
      if (fill_en && sel)      line_q <= fill_line;
      else if (byte_en && sel) line_q[byte_off*8 +: 8] <= byte_data;
    end

    assign line_a[g] = line_q;
  end

  assign rd_line = line_a[{rd_idx, rd_way}];

  // A fill and a byte merge never share a cycle
  assert_one_writer_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(fill_en && byte_en));
endmodule

// File: rtl/bcache_ctrl.sv
module bcache_ctrl
  import bcache_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [7:0]        req_wdata,
  output logic              resp_valid,
  output logic              resp_hit,
  output logic [7:0]        resp_rdata,
  output logic              mem_valid,
  output logic              mem_write,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [LINE_W-1:0] mem_wdata,
  input  logic              mem_ready,
  input  logic [LINE_W-1:0] mem_rdata,
  output logic [IDX_W-1:0]  lk_idx,
  output logic [TAG_W-1:0]  lk_tag,
  input  logic              hit,
  input  logic [WAY_W-1:0]  hit_way,
  input  logic [WAY_W-1:0]  vic_way,
  input  logic              vic_valid,
  input  logic              vic_dirty,
  input  logic [TAG_W-1:0]  vic_tag,
  output logic              fill_en,
  output logic              dirty_en,
  output logic [IDX_W-1:0]  upd_idx,
  output logic [WAY_W-1:0]  upd_way,
  output logic [TAG_W-1:0]  fill_tag,
  output logic [LINE_W-1:0] fill_line,
  output logic [WAY_W-1:0]  rd_way,
  input  logic [LINE_W-1:0] rd_line,
  output logic              byte_en,
  output logic [OFF_W-1:0]  byte_off,
  output logic [7:0]        byte_data
);
  ctrl_state_t state_q, state_d;

  logic [ADDR_W-1:0] addr_q;
  logic              write_q;
  logic [7:0]        wdata_q;
  logic              miss_q;
  logic [WAY_W-1:0]  vway_q;
  logic [TAG_W-1:0]  vtag_q;
  logic              rv_q, rh_q;
  logic [7:0]        rd_q;

  logic ld_req, ld_vic, ld_resp;

  logic [OFF_W-1:0] r_off;
  logic [IDX_W-1:0] r_idx;
  logic [TAG_W-1:0] r_tag;
  assign r_off = addr_q[OFF_W-1:0];
  assign r_idx = addr_q[OFF_W +: IDX_W];
  assign r_tag = addr_q[ADDR_W-1 -: TAG_W];

  // Next-state process
  always_comb begin
    state_d  = state_q;
    ld_req   = 1'b0;
    ld_vic   = 1'b0;
    ld_resp  = 1'b0;
    fill_en  = 1'b0;
    dirty_en = 1'b0;
    byte_en  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (req_valid) begin
          ld_req  = 1'b1;
          state_d = ST_LOOKUP;
        end
      end
      ST_LOOKUP: begin
        if (hit) begin
          ld_resp  = 1'b1;
          byte_en  = write_q;
          dirty_en = write_q;
          state_d  = ST_RESP;
        end else begin
          ld_vic  = 1'b1;
          state_d = (vic_valid && vic_dirty) ? ST_WBACK : ST_FILL;
        end
      end
      ST_WBACK: begin
        if (mem_ready) state_d = ST_FILL;
      end
      ST_FILL: begin
        if (mem_ready) begin
          fill_en = 1'b1;
          state_d = ST_LOOKUP;
        end
      end
      ST_RESP: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  // Register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      rv_q    <= 1'b0;
      miss_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      rv_q    <= ld_resp;
      if (ld_req)      miss_q <= 1'b0;
      else if (ld_vic) miss_q <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (ld_req) begin
      addr_q  <= req_addr;
      write_q <= req_write;
      wdata_q <= req_wdata;
    end
    if (ld_vic) begin
      vway_q <= vic_way;
      vtag_q <= vic_tag;
    end
    if (ld_resp) begin
      rh_q <= !miss_q;
      rd_q <= write_q ? wdata_q : rd_line[r_off*8 +: 8];
    end
  end

  assign lk_idx    = r_idx;
  assign lk_tag    = r_tag;
  assign upd_idx   = r_idx;
  assign upd_way   = (state_q == ST_FILL) ? vway_q : hit_way;
  assign fill_tag  = r_tag;
  assign fill_line = mem_rdata;
  assign rd_way    = (state_q == ST_WBACK) ? vway_q : hit_way;
  assign byte_off  = r_off;
  assign byte_data = wdata_q;

  assign req_ready  = (state_q == ST_IDLE);
  assign resp_valid = rv_q;
  assign resp_hit   = rh_q;
  assign resp_rdata = rd_q;

  assign mem_valid = (state_q == ST_WBACK) || (state_q == ST_FILL);
  assign mem_write = (state_q == ST_WBACK);
  assign mem_addr  = (state_q == ST_WBACK) ? {vtag_q, r_idx, {OFF_W{1'b0}}}
                                           : {r_tag, r_idx, {OFF_W{1'b0}}};
  assign mem_wdata = rd_line;

  // Memory request held until accepted
  assert_mem_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) && $stable(mem_write)));

  // Response strobe lasts one cycle
  assert_resp_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |=> !resp_valid);

  // A write-back follows a miss only when the chosen victim was dirty
  assert_wb_dirty_only_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_LOOKUP && !hit) |=> (mem_write == $past(vic_valid && vic_dirty)));

  // A completed fill is found by the following lookup
  assert_fill_then_hit_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_FILL && mem_ready) |=> (state_q == ST_LOOKUP && hit));
endmodule

// File: rtl/bcache_top.sv
module bcache_top
  import bcache_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [7:0]        req_wdata,
  output logic              resp_valid,
  output logic              resp_hit,
  output logic [7:0]        resp_rdata,
  output logic              mem_valid,
  output logic              mem_write,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [LINE_W-1:0] mem_wdata,
  input  logic              mem_ready,
  input  logic [LINE_W-1:0] mem_rdata
);
  // Asynchronous assertion, synchronous release
  logic [1:0] rst_sync;
  logic       srst_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign srst_n = rst_sync[1];

  logic [WAY_W-1:0]  rnd_way, hit_way, vic_way, upd_way, rd_way;
  logic [IDX_W-1:0]  lk_idx, upd_idx;
  logic [TAG_W-1:0]  lk_tag, vic_tag, fill_tag;
  logic              hit, vic_valid, vic_dirty, fill_en, dirty_en, byte_en;
  logic [LINE_W-1:0] rd_line, fill_line;
  logic [OFF_W-1:0]  byte_off;
  logic [7:0]        byte_data;

  bcache_lfsr u_rnd (
    .clk     (clk),
    .rst_n   (srst_n),
    .rnd_way (rnd_way)
  );

  bcache_tags u_tags (
    .clk       (clk),
    .rst_n     (srst_n),
    .lk_idx    (lk_idx),
    .lk_tag    (lk_tag),
    .rnd_way   (rnd_way),
    .hit       (hit),
    .hit_way   (hit_way),
    .vic_way   (vic_way),
    .vic_valid (vic_valid),
    .vic_dirty (vic_dirty),
    .vic_tag   (vic_tag),
    .fill_en   (fill_en),
    .dirty_en  (dirty_en),
    .upd_idx   (upd_idx),
    .upd_way   (upd_way),
    .fill_tag  (fill_tag)
  );

  bcache_data u_data (
    .clk       (clk),
    .rst_n     (srst_n),
    .rd_idx    (lk_idx),
    .rd_way    (rd_way),
    .rd_line   (rd_line),
    .wr_idx    (upd_idx),
    .wr_way    (upd_way),
    .fill_en   (fill_en),
    .fill_line (fill_line),
    .byte_en   (byte_en),
    .byte_off  (byte_off),
    .byte_data (byte_data)
  );

  bcache_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (srst_n),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .req_write  (req_write),
    .req_addr   (req_addr),
    .req_wdata  (req_wdata),
    .resp_valid (resp_valid),
    .resp_hit   (resp_hit),
    .resp_rdata (resp_rdata),
    .mem_valid  (mem_valid),
    .mem_write  (mem_write),
    .mem_addr   (mem_addr),
    .mem_wdata  (mem_wdata),
    .mem_ready  (mem_ready),
    .mem_rdata  (mem_rdata),
    .lk_idx     (lk_idx),
    .lk_tag     (lk_tag),
    .hit        (hit),
    .hit_way    (hit_way),
    .vic_way    (vic_way),
    .vic_valid  (vic_valid),
    .vic_dirty  (vic_dirty),
    .vic_tag    (vic_tag),
    .fill_en    (fill_en),
    .dirty_en   (dirty_en),
    .upd_idx    (upd_idx),
    .upd_way    (upd_way),
    .fill_tag   (fill_tag),
    .fill_line  (fill_line),
    .rd_way     (rd_way),
    .rd_line    (rd_line),
    .byte_en    (byte_en),
    .byte_off   (byte_off),
    .byte_data  (byte_data)
  );
endmodule

// File: tb/bcache_top_test.sv
`timescale 1ns/1ps
module bcache_top_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_write, req_ready;
  logic [7:0]  req_addr, req_wdata;
  logic        resp_valid, resp_hit;
  logic [7:0]  resp_rdata;
  logic        mem_valid, mem_write, mem_ready;
  logic [7:0]  mem_addr;
  logic [15:0] mem_wdata, mem_rdata;

  always #2 clk = ~clk;

  bcache_top uut (.*);

  int checks = 0, errors = 0;
  bit done = 0;
  logic [7:0] arch [256];
  logic [7:0] mem  [256];
  int acc_fill, acc_wb, order_bad, lat;
  logic [7:0] wb_addr, fill_addr;

  function automatic logic [7:0] init_byte(input int a);
    return 8'((a * 13) ^ 8'h5A);
  endfunction

  function automatic logic [7:0] exp_data(input bit wr, input logic [7:0] a, input logic [7:0] d);
    return wr ? d : arch[a];
  endfunction

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Memory responder
  initial begin
    mem_ready = 0; mem_rdata = '0; lat = 0;
    forever begin
      @(negedge clk);
      if (mem_ready) mem_ready = 0;
      else if (mem_valid && rst_n) begin
        if (lat > 0) lat--;
        else begin
          chk(mem_addr[0] == 1'b0, "R4", "line address offset bit", mem_addr[0], 0);
          if (mem_write) begin
            acc_wb++; wb_addr = mem_addr;
            if (acc_fill > 0) order_bad = 1;
            chk(mem_wdata == {arch[{mem_addr[7:1],1'b1}], arch[mem_addr]}, "R6",
                "write-back data", mem_wdata, {arch[{mem_addr[7:1],1'b1}], arch[mem_addr]});
            mem[mem_addr] = mem_wdata[7:0];
            mem[{mem_addr[7:1],1'b1}] = mem_wdata[15:8];
          end else begin
            acc_fill++; fill_addr = mem_addr;
            mem_rdata = {mem[{mem_addr[7:1],1'b1}], mem[mem_addr]};
          end
          mem_ready = 1;
          lat = int'($urandom % 3);
        end
      end
    end
  end

  task automatic access(input bit wr, input logic [7:0] a, input logic [7:0] d,
                        output bit hit, output logic [7:0] rd);
    logic [7:0] exp;
    acc_fill = 0; acc_wb = 0; order_bad = 0;
    exp = exp_data(wr, a, d);
    @(negedge clk);
    req_valid = 1; req_write = wr; req_addr = a; req_wdata = d;
    while (!req_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    req_valid = 0;
    while (!resp_valid) @(negedge clk);
    hit = resp_hit; rd = resp_rdata;
    chk(rd == exp, "R2", $sformatf("data at %0h", a), rd, exp);
    chk(hit == (acc_fill == 0), "R3", "hit flag versus memory traffic", hit, acc_fill == 0);
    chk(acc_fill == (hit ? 0 : 1), "R4", "fill count", acc_fill, hit ? 0 : 1);
    if (!hit) chk(fill_addr == {a[7:1],1'b0}, "R4", "fill address", fill_addr, {a[7:1],1'b0});
    chk(order_bad == 0, "R6", "write-back before fill", order_bad, 0);
    if (wr) arch[a] = d;
    @(negedge clk);
    chk(resp_valid == 0, "R10", "response pulse width", resp_valid, 0);
  endtask

  task automatic do_reset();
    req_valid = 0; req_write = 0; req_addr = 0; req_wdata = 0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
    for (int i = 0; i < 256; i++) arch[i] = mem[i];
  endtask

  // Watchdog
  initial begin
    #(4 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    bit h; logic [7:0] r; int unsigned sd; int hits;
    sd = $urandom(32'h1F2E);
    for (int i = 0; i < 256; i++) mem[i] = init_byte(i);
    do_reset();

    // R1: reset state
    chk(req_ready == 1, "R1", "req_ready after reset", req_ready, 1);
    chk(resp_valid == 0, "R1", "resp_valid after reset", resp_valid, 0);
    chk(mem_valid == 0, "R1", "mem_valid after reset", mem_valid, 0);
    access(0, 8'h00, 0, h, r);
    chk(h == 0, "R1", "first access misses", h, 0);
    access(0, 8'h01, 0, h, r);
    chk(h == 1, "R3", "other byte of filled line hits", h, 1);

    // R5: write-allocate
    access(1, 8'h46, 8'hC3, h, r);
    chk(h == 0, "R5", "write miss", h, 0);
    access(0, 8'h46, 0, h, r);
    chk(h == 1, "R5", "written byte resident", h, 1);
    access(0, 8'h47, 0, h, r);
    chk(r == mem[8'h47], "R5", "neighbour byte unchanged", r, mem[8'h47]);
    access(1, 8'h47, 8'h9E, h, r);
    chk(h == 1 && acc_fill == 0 && acc_wb == 0, "R5", "write hit quiet", h, 1);

    // R8: four tags per set stay resident
    do_reset();
    for (int t = 0; t < 4; t++) access(0, 8'(t * 4), 0, h, r);
    for (int t = 0; t < 4; t++) access(0, 8'(t * 4 + 2), 0, h, r);
    for (int t = 0; t < 4; t++) begin
      access(0, 8'(t * 4 + 1), 0, h, r);
      chk(h == 1, "R8", $sformatf("set 0 tag %0d resident", t), h, 1);
      access(0, 8'(t * 4 + 3), 0, h, r);
      chk(h == 1, "R8", $sformatf("set 1 tag %0d resident", t), h, 1);
    end
    // R7: clean eviction
    access(0, 8'h10, 0, h, r);
    chk(h == 0 && acc_wb == 0, "R7", "clean victim write-backs", acc_wb, 0);
    // R9: other set intact
    hits = 0;
    for (int t = 0; t < 4; t++) begin access(0, 8'(t * 4 + 2), 0, h, r); hits += int'(h); end
    chk(hits == 4, "R9", "set 1 hits after set 0 eviction", hits, 4);
    access(0, 8'h11, 0, h, r);
    chk(h == 1, "R9", "new line resident", h, 1);

    // R6: dirty eviction
    do_reset();
    for (int t = 0; t < 4; t++) access(1, 8'(t * 4), 8'(8'hA0 + t), h, r);
    access(0, 8'h10, 0, h, r);
    chk(acc_wb == 1, "R6", "write-back count", acc_wb, 1);
    chk(wb_addr[1:0] == 2'b00 && wb_addr < 8'h10, "R6", "victim line address", wb_addr, 0);
    begin
      logic [7:0] ev; ev = wb_addr;
      access(0, ev, 0, h, r);
      chk(h == 0, "R6", "evicted line refetched", h, 0);
    end

    // Random phase
    for (int i = 0; i < 600; i++) begin
      logic [7:0] a, d;
      a = 8'($urandom); d = 8'($urandom);
      access(($urandom % 3) == 0, a, d, h, r);
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule